// File: doc/BRIEF.md
# Scalar Bit Scan and Mask Unit

This unit answers bit-level questions about a scalar operand: how many bits are clear, where the lowest set or clear bit sits, where the highest set bit sits, how many leading zeros there are, and how far the sign bit's value runs down from the top. It also turns a lane mask into whole groups of four lanes, or squeezes each group of four into a single bit. A width select treats the operand as either its low 32 bits or all 64 bits.

The caller presents the operand, an opcode and the width select with a one-cycle valid strobe. One clock later the unit raises `valid_o` for one cycle with the result. The result then stays on `result_o` until the next strobe. The search operations return a signed 32-bit count or index, sign-extended to 64 bits. A search with no answer returns -1, which reads as all ones. The mask operations return a mask as wide as the operand. An opcode outside the defined set returns zero and raises `err_o`.

Top module: `scalar_bitscan_unit`

## Requirements
- R1: Opcode 0 (count clear bits) returns the active width (32 when `wide_i`=0, 64 when `wide_i`=1) minus the number of set bits in the active operand.
- R2: Opcode 1 (lowest clear bit) returns the index of the lowest 0 bit within the active width, or -1 when every active bit is 1.
- R3: Opcode 2 (lowest set bit) returns the index of the lowest 1 bit, or -1 when the active operand is zero.
- R4: Opcode 3 (highest set bit) returns the index of the highest 1 bit, or -1 when the active operand is zero.
- R5: Opcode 4 (leading zeros) returns active width - 1 minus the highest set index, or -1 when the active operand is zero.
- R6: Opcode 5 (sign run) returns how many bits, counted from the top active bit downward and including it, equal the top active bit before the first bit that differs. It returns -1 when the active operand is all zeros or all ones.
- R7: Opcode 6 (quad expand) returns, for every 4-bit group at bits [4g+3:4g], 4'hF if any bit of that group is set and 4'h0 otherwise.
- R8: Opcode 7 (quad compact) returns a value whose bit g is the OR of operand bits [4g+3:4g], with every bit above the last group cleared.
- R9: With `wide_i`=0, `operand_i[63:32]` has no effect on any result.
- R10: `valid_o` and the new `result_o`/`err_o` appear on the clock edge after the one that sampled `valid_i`=1. Without a strobe, `valid_o` is 0 and `result_o` holds its value.
- R11: Opcodes 8 to 15 give `result_o`=0 and `err_o`=1. Defined opcodes give `err_o`=0.
- R12: While `rst_ni` is low, `valid_o`, `err_o` and `result_o` are 0.
- R13: Search results (opcodes 0 to 5) are sign-extended from 32 to 64 bits, so -1 appears as all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| wide_i | input | 1 | 1: 64-bit operand, 0: low 32 bits |
| operand_i | input | 64 | Operand |
| valid_o | output | 1 | Result valid, one cycle after strobe |
| result_o | output | 64 | Result |
| err_o | output | 1 | Undefined opcode was issued |

## Verification
The hardest cases to reach are the boundaries where the width select and the operand's upper half interact. Examples are an operand that is all ones in its low 32 bits with arbitrary upper bits, and a narrow sign-run scan whose sign bit is bit 31 while bit 63 holds the opposite value. The stimulus issues the same operand in both widths, back to back. It fills the upper half with patterns that would change the answer if it leaked through. It also walks single set bits to both ends of each width, so the no-answer value and the extreme indices are all produced.

// File: rtl/bitscan_pkg.sv
package bitscan_pkg;
  typedef enum logic [3:0] {
    OP_CNT_ZERO  = 4'd0,
    OP_LOW_ZERO  = 4'd1,
    OP_LOW_ONE   = 4'd2,
    OP_HIGH_ONE  = 4'd3,
    OP_LEAD_ZERO = 4'd4,
    OP_SIGN_RUN  = 4'd5,
    OP_QUAD_EXP  = 4'd6,
    OP_QUAD_CMP  = 4'd7
  } bs_op_e;
endpackage

// File: rtl/bs_popcnt.sv
module bs_popcnt #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/bs_find.sv
module bs_find #(
  parameter int W        = 64,
  parameter bit FROM_MSB = 1'b0,
  localparam int IW      = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  assign found_o = |vec_i;

  generate
    if (FROM_MSB) begin : g_msb
      // ascending scan: last hit is the highest set bit
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) if (vec_i[i]) idx_o = IW'(i);
      end
    end else begin : g_lsb
      // descending scan: last hit is the lowest set bit
      always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) if (vec_i[i]) idx_o = IW'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/bs_quad.sv
module bs_quad #(
  parameter int W  = 64,
  localparam int G = W / 4
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] expand_o,
  output logic [G-1:0] compact_o
);
  for (genvar g = 0; g < G; g++) begin : g_grp
    assign compact_o[g]         = |vec_i[4*g +: 4];
    assign expand_o[4*g +: 4]   = {4{compact_o[g]}};
  end
endmodule

// File: rtl/scalar_bitscan_unit.sv
module scalar_bitscan_unit
  import bitscan_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int RES_W    = 32,
  localparam int IW      = $clog2(DATA_W),
  localparam int CW      = $clog2(DATA_W) + 1,
  localparam int GW      = DATA_W / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              err_o
);
  logic [DATA_W-1:0] act_mask, act_val, inv_val, diff_val;
  logic              sign_bit;
  logic [RES_W-1:0]  width_v;

  assign act_mask = wide_i ? {DATA_W{1'b1}}
                           : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign act_val  = operand_i & act_mask;
  assign inv_val  = ~operand_i & act_mask;
  assign sign_bit = wide_i ? operand_i[DATA_W-1] : operand_i[NARROW_W-1];
  // bits that differ from the sign bit; zero for all-0 and all-1 operands
  assign diff_val = (operand_i ^ {DATA_W{sign_bit}}) & act_mask;
  assign width_v  = wide_i ? RES_W'(DATA_W) : RES_W'(NARROW_W);

  logic [CW-1:0] pop_cnt;
  bs_popcnt #(.W(DATA_W)) u_pop (.vec_i(act_val), .cnt_o(pop_cnt));

  logic          one_lo_f, zero_lo_f, one_hi_f, diff_hi_f;
  logic [IW-1:0] one_lo_i, zero_lo_i, one_hi_i, diff_hi_i;

  bs_find #(.W(DATA_W), .FROM_MSB(1'b0)) u_one_lo
    (.vec_i(act_val),  .found_o(one_lo_f),  .idx_o(one_lo_i));
  bs_find #(.W(DATA_W), .FROM_MSB(1'b0)) u_zero_lo
    (.vec_i(inv_val),  .found_o(zero_lo_f), .idx_o(zero_lo_i));
  bs_find #(.W(DATA_W), .FROM_MSB(1'b1)) u_one_hi
    (.vec_i(act_val),  .found_o(one_hi_f),  .idx_o(one_hi_i));
  bs_find #(.W(DATA_W), .FROM_MSB(1'b1)) u_diff_hi
    (.vec_i(diff_val), .found_o(diff_hi_f), .idx_o(diff_hi_i));

  logic [DATA_W-1:0] quad_exp;
  logic [GW-1:0]     quad_cmp;
  bs_quad #(.W(DATA_W)) u_quad
    (.vec_i(act_val), .expand_o(quad_exp), .compact_o(quad_cmp));

  logic [RES_W-1:0]  scal_res;
  logic [DATA_W-1:0] next_res;
  logic              next_err, is_scal;

  always_comb begin
    scal_res = '0;
    is_scal  = 1'b1;
    next_err = 1'b0;
    next_res = '0;
    case (op_i)
      OP_CNT_ZERO:  scal_res = width_v - RES_W'(pop_cnt);
      OP_LOW_ZERO:  scal_res = zero_lo_f ? RES_W'(zero_lo_i) : '1;
      OP_LOW_ONE:   scal_res = one_lo_f  ? RES_W'(one_lo_i)  : '1;
      OP_HIGH_ONE:  scal_res = one_hi_f  ? RES_W'(one_hi_i)  : '1;
      OP_LEAD_ZERO: scal_res = one_hi_f  ? width_v - 1'b1 - RES_W'(one_hi_i) : '1;
      OP_SIGN_RUN:  scal_res = diff_hi_f ? width_v - 1'b1 - RES_W'(diff_hi_i) : '1;
      OP_QUAD_EXP: begin
        is_scal  = 1'b0;
        next_res = quad_exp;
      end
      OP_QUAD_CMP: begin
        is_scal  = 1'b0;
        next_res = {{(DATA_W-GW){1'b0}}, quad_cmp};
      end
      default: begin
        is_scal  = 1'b0;
        next_err = 1'b1;
      end
    endcase
    if (is_scal) next_res = {{(DATA_W-RES_W){scal_res[RES_W-1]}}, scal_res};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= next_res;
        err_o    <= next_err;
      end
    end
  end
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              wide_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              err_o
);
  function automatic bit nibbles_uniform(logic [DATA_W-1:0] v);
    bit ok = 1'b1;
    for (int g = 0; g < DATA_W / 4; g++)
      if (v[4*g +: 4] != 4'h0 && v[4*g +: 4] != 4'hF) ok = 1'b0;
    return ok;
  endfunction

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
  a_r11_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> result_o == '0);
  a_r11_err_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i < 4'd8) |=> !err_o);
  a_r7_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd6) |=> nibbles_uniform(result_o));
  a_r8_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd7) |=> result_o[DATA_W-1:DATA_W/4] == '0);
  a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd3 && !wide_i) |=>
      (result_o == '1 || result_o < 64'd32));
endmodule

bind scalar_bitscan_unit bs_checker #(.DATA_W(DATA_W)) u_bs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .wide_i(wide_i), .operand_i(operand_i), .valid_o(valid_o),
  .result_o(result_o), .err_o(err_o)
);

// File: tb/tb_scalar_bitscan_unit.sv
module tb_scalar_bitscan_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        valid_o, err_o;
  logic [63:0] result_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  scalar_bitscan_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .wide_i(wide_i), .operand_i(operand_i), .valid_o(valid_o),
    .result_o(result_o), .err_o(err_o)
  );

  localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;

  function automatic logic [63:0] sx(int v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  // independent reference, bit by bit
  function automatic logic [63:0] ref_model(logic [3:0] op, bit wide, logic [63:0] v);
    int w = wide ? 64 : 32;
    int r = -1;
    int n = 0;
    logic [63:0] m = '0;
    logic s;
    case (op)
      4'd0: begin for (int i = 0; i < w; i++) if (!v[i]) n++; return sx(n); end
      4'd1: begin for (int i = w - 1; i >= 0; i--) if (!v[i]) r = i; return sx(r); end
      4'd2: begin for (int i = w - 1; i >= 0; i--) if (v[i]) r = i; return sx(r); end
      4'd3: begin for (int i = 0; i < w; i++) if (v[i]) r = i; return sx(r); end
      4'd4: begin
        for (int i = 0; i < w; i++) if (v[i]) r = i;
        return (r < 0) ? M1 : sx(w - 1 - r);
      end
      4'd5: begin
        s = v[w-1];
        for (int i = w - 1; i >= 0; i--) begin
          if (v[i] != s) begin r = n; break; end
          n++;
        end
        return sx(r);
      end
      4'd6: begin
        for (int g = 0; g < w / 4; g++) if (v[4*g +: 4] != 0) m[4*g +: 4] = 4'hF;
        return m;
      end
      4'd7: begin
        for (int g = 0; g < w / 4; g++) m[g] = (v[4*g +: 4] != 0);
        return m;
      end
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one op; sample at the negedge after the capturing posedge
  task automatic issue(logic [3:0] op, bit wide, logic [63:0] v);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; wide_i = wide; operand_i = v;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run(string tag, logic [3:0] op, bit wide, logic [63:0] v);
    issue(op, wide, v);
    check({tag, " result"}, result_o, ref_model(op, wide, v));
    check({tag, " valid"}, {63'd0, valid_o}, 64'd1);
    check({tag, " err"}, {63'd0, err_o}, 64'd0);
  endtask

  task automatic t_reset;
    check("R12 valid_o", {63'd0, valid_o}, 64'd0);
    check("R12 err_o", {63'd0, err_o}, 64'd0);
    check("R12 result_o", result_o, 64'd0);
  endtask

  task automatic t_count_zero;
    run("R1 zero narrow", 4'd0, 0, 64'd0);
    check("R1 literal 32", result_o, 64'd32);
    run("R1 zero wide", 4'd0, 1, 64'd0);
    check("R1 literal 64", result_o, 64'd64);
    run("R1 mix", 4'd0, 1, 64'hF0F0_0000_1234_5678);
  endtask

  task automatic t_low_zero;
    run("R2 all ones narrow", 4'd1, 0, 64'h0000_0000_FFFF_FFFF);
    check("R2 literal -1", result_o, M1);
    run("R2 all ones low wide", 4'd1, 1, 64'h0000_0000_FFFF_FFFF);
    check("R2 literal 32", result_o, 64'd32);
    run("R2 all ones wide", 4'd1, 1, M1);
    run("R2 bit3", 4'd1, 0, 64'h0000_0000_0000_0007);
  endtask

  task automatic t_low_one;
    run("R3 zero", 4'd2, 1, 64'd0);
    check("R3 literal -1", result_o, M1);
    run("R3 0x80", 4'd2, 0, 64'h80);
    check("R3 literal 7", result_o, 64'd7);
    run("R3 top wide", 4'd2, 1, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_high_one;
    run("R4 zero", 4'd3, 0, 64'd0);
    run("R4 top wide", 4'd3, 1, 64'h8000_0000_0000_0000);
    check("R4 literal 63", result_o, 64'd63);
    for (int i = 0; i < 64; i += 9) run("R4 walk", 4'd3, 1, 64'd1 << i);
  endtask

  task automatic t_lead_zero;
    run("R5 one narrow", 4'd4, 0, 64'd1);
    check("R5 literal 31", result_o, 64'd31);
    run("R5 top wide", 4'd4, 1, 64'h8000_0000_0000_0000);
    check("R5 literal 0", result_o, 64'd0);
    run("R5 zero", 4'd4, 1, 64'd0);
  endtask

  task automatic t_sign_run;
    run("R6 neg narrow", 4'd5, 0, 64'h0000_0000_FFFF_0000);
    check("R6 literal 16", result_o, 64'd16);
    run("R6 one narrow", 4'd5, 0, 64'd1);
    check("R6 literal 31", result_o, 64'd31);
    run("R6 zero", 4'd5, 1, 64'd0);
    run("R6 ones narrow", 4'd5, 0, 64'h1234_5678_FFFF_FFFF);
    check("R6 literal -1", result_o, M1);
    run("R6 ones wide", 4'd5, 1, M1);
    run("R6 wide", 4'd5, 1, 64'hFFFF_FFF0_0000_0000);
  endtask

  task automatic t_quad;
    run("R7 narrow", 4'd6, 0, 64'h0000_0000_0010_0201);
    check("R7 literal", result_o, 64'h0000_0000_00F0_0F0F);
    run("R7 wide", 4'd6, 1, 64'h8000_0400_0000_0001);
    run("R8 wide", 4'd7, 1, 64'h8000_0000_0000_0001);
    check("R8 literal", result_o, 64'h8001);
    run("R8 narrow", 4'd7, 0, 64'hFFFF_FFFF_0F00_00F1);
  endtask

  task automatic t_narrow_ignore;
    for (int op = 0; op < 8; op++) begin
      issue(4'(op), 0, 64'h0000_0000_8000_0100);
      check("R9 ref", result_o, ref_model(4'(op), 0, 64'h0000_0000_8000_0100));
      issue(4'(op), 0, 64'hA5C3_7E19_8000_0100);
      check("R9 upper ignored", result_o, ref_model(4'(op), 0, 64'h0000_0000_8000_0100));
    end
  endtask

  task automatic t_sign_ext;
    run("R13 neg", 4'd2, 0, 64'd0);
    check("R13 all ones", result_o, M1);
  endtask

  task automatic t_undef;
    issue(4'd9, 1, 64'h1234);
    check("R11 result zero", result_o, 64'd0);
    check("R11 err set", {63'd0, err_o}, 64'd1);
    issue(4'd15, 0, M1);
    check("R11 err 15", {63'd0, err_o}, 64'd1);
    issue(4'd2, 0, 64'h10);
    check("R11 err clears", {63'd0, err_o}, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] held;
    issue(4'd0, 1, 64'hFF);
    held = result_o;
    @(negedge clk_i);
    operand_i = M1; op_i = 4'd6;
    @(negedge clk_i);
    check("R10 valid low", {63'd0, valid_o}, 64'd0);
    check("R10 result held", result_o, held);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_count_zero;
    t_low_zero;
    t_low_one;
    t_high_one;
    t_lead_zero;
    t_sign_run;
    t_quad;
    t_narrow_ignore;
    t_sign_ext;
    t_undef;
    t_hold;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule